// File: doc/BRIEF.md
# Synchronous Memory Sleep Controller

This block sequences a synchronous memory into and out of a low-power sleep state. An active-high sleep request arrives with no relation to the clock. The block passes it through a flop synchroniser. It then runs a fixed-length entry phase, holds the sleep state, and runs a fixed-length recovery phase before it allows accesses again. While the block is away from the awake state, it tells the memory's output stage to float its data pins and it withholds permission for new accesses.

The surrounding memory logic reports whether the device is currently deselected, and it reports activity on its access start strobes and chip enables. Two kinds of protocol violation set a sticky error flag, and only reset clears that flag. The first is any such activity outside the awake state. The second is a request that arrives while the device is still selected.

Top module: `slp_ctrl`

## Requirements
- R1: After reset, sleep_active=0, access_ok=1, force_hiz=0 and proto_err=0.
- R2: The request passes through SYNC_STAGES flops (default 2). The block leaves the awake state (access_ok low, force_hiz high) at the (SYNC_STAGES+1)th rising edge after the edge where sleep_req is first sampled high.
- R3: The entry phase lasts exactly ENTER_CYCLES cycles (default 2), with force_hiz=1, access_ok=0 and sleep_active=0. sleep_active then rises and stays high while the synchronised request stays high.
- R4: After sleep_req is sampled low, sleep_active falls at the (SYNC_STAGES+1)th edge. A recovery phase of EXIT_CYCLES cycles (default 2) follows, with force_hiz=1 and access_ok=0. The block then returns to awake.
- R5: force_hiz is high in every state except awake, and access_ok is high only in awake. sleep_active never coexists with access_ok.
- R6: If the synchronised request drops during the entry phase, the block goes straight to recovery, and sleep_active never rises.
- R7: Any bit of strobe_act or ce_act high in a cycle outside awake sets proto_err at the next edge. The same activity in awake, with no request pending, leaves proto_err low.
- R8: If deselected is low in the cycle where the synchronised request moves the block out of awake, proto_err is set at that edge.
- R9: proto_err stays high through every later state until reset.
- R10: The active-low reset is asynchronous. It returns all outputs to their R1 values from any state, including the middle of entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_req | input | 1 | Asynchronous active-high sleep request |
| deselected | input | 1 | High when the memory is currently deselected |
| strobe_act | input | NUM_STROBES | One bit per access start strobe, high when active |
| ce_act | input | NUM_CE | One bit per chip enable, high when asserting selection |
| sleep_active | output | 1 | High while in the sleep state |
| access_ok | output | 1 | High only when new accesses are permitted |
| force_hiz | output | 1 | Forces the memory data outputs to high impedance |
| proto_err | output | 1 | Sticky protocol-violation flag |

## Verification
The hardest case to reach is a request withdrawn inside the entry phase. The release has to land so that the synchroniser output falls in the last entry cycle, one edge before the counter would move the block to sleep. The stimulus holds the request for exactly two samples and drops it in the third. The synchronised value then stays high through the first entry cycle and is low by the second. The bench confirms that recovery follows and that sleep_active never rises. A separate sequence resets the block mid-entry to show that the asynchronous reset pulls the block out of a transient state.

// File: rtl/slp_pkg.sv
package slp_pkg;
   typedef enum logic [1:0] {
      ST_AWAKE   = 2'd0,
      ST_ENTER   = 2'd1,
      ST_ASLEEP  = 2'd2,
      ST_RECOVER = 2'd3
   } slp_state_e;
endpackage

// File: rtl/slp_req_sync.sv
module slp_req_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_async,
   output logic req_sync
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("slp_req_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], req_async};
   end

   assign req_sync = chain_q[STAGES-1];
endmodule

// File: rtl/slp_phase_fsm.sv
module slp_phase_fsm
   import slp_pkg::*;
#(
   parameter int ENTER_CYCLES = 2,
   parameter int EXIT_CYCLES  = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req_s,
   output slp_state_e state
);
   localparam int MAX_CYC = (ENTER_CYCLES > EXIT_CYCLES) ? ENTER_CYCLES : EXIT_CYCLES;
   localparam int CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;
   localparam logic [CNT_W-1:0] ENT_LAST = CNT_W'(ENTER_CYCLES - 1);
   localparam logic [CNT_W-1:0] EXT_LAST = CNT_W'(EXIT_CYCLES - 1);

   generate
      if (ENTER_CYCLES < 1 || EXIT_CYCLES < 1) begin : g_bad_cycles
         $error("slp_phase_fsm: phase lengths must be at least 1");
      end
   endgenerate

   slp_state_e       state_q, state_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;

   always_comb begin
      state_d = state_q;
      cnt_d   = cnt_q + CNT_W'(1);
      case (state_q)
         ST_AWAKE: begin
            cnt_d = '0;
            if (req_s) state_d = ST_ENTER;
         end
         ST_ENTER: begin
            if (!req_s) begin
               state_d = ST_RECOVER;
               cnt_d   = '0;
            end else if (cnt_q == ENT_LAST) begin
               state_d = ST_ASLEEP;
               cnt_d   = '0;
            end
         end
         ST_ASLEEP: begin
            cnt_d = '0;
            if (!req_s) state_d = ST_RECOVER;
         end
         ST_RECOVER: begin
            if (req_s) begin
               state_d = ST_ENTER;
               cnt_d   = '0;
            end else if (cnt_q == EXT_LAST) begin
               state_d = ST_AWAKE;
               cnt_d   = '0;
            end
         end
         default: begin
            state_d = ST_AWAKE;
            cnt_d   = '0;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_AWAKE;
         cnt_q   <= '0;
      end else begin
         state_q <= state_d;
         cnt_q   <= cnt_d;
      end
   end

   assign state = state_q;
endmodule

// File: rtl/slp_err_track.sv
module slp_err_track
   import slp_pkg::*;
#(
   parameter int NUM_STROBES = 2,
   parameter int NUM_CE      = 3
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  slp_state_e             state,
   input  logic                   req_s,
   input  logic                   deselected,
   input  logic [NUM_STROBES-1:0] strobe_act,
   input  logic [NUM_CE-1:0]      ce_act,
   output logic                   proto_err
);
   logic any_act, act_bad, entry_bad, err_q;

   assign any_act   = (|strobe_act) | (|ce_act);
   assign act_bad   = (state != ST_AWAKE) && any_act;
   assign entry_bad = (state == ST_AWAKE) && req_s && !deselected;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) err_q <= 1'b0;
      else        err_q <= err_q | act_bad | entry_bad;
   end

   assign proto_err = err_q;
endmodule

// File: rtl/slp_ctrl.sv
module slp_ctrl
   import slp_pkg::*;
#(
   parameter int SYNC_STAGES  = 2,
   parameter int ENTER_CYCLES = 2,
   parameter int EXIT_CYCLES  = 2,
   parameter int NUM_STROBES  = 2,
   parameter int NUM_CE       = 3
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   sleep_req,
   input  logic                   deselected,
   input  logic [NUM_STROBES-1:0] strobe_act,
   input  logic [NUM_CE-1:0]      ce_act,
   output logic                   sleep_active,
   output logic                   access_ok,
   output logic                   force_hiz,
   output logic                   proto_err
);
   generate
      if (NUM_STROBES < 1 || NUM_CE < 1) begin : g_bad_widths
         $error("slp_ctrl: strobe and enable counts must be at least 1");
      end
   endgenerate

   logic       req_s;
   slp_state_e state;

   slp_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_async (sleep_req),
      .req_sync  (req_s)
   );

   slp_phase_fsm #(
      .ENTER_CYCLES (ENTER_CYCLES),
      .EXIT_CYCLES  (EXIT_CYCLES)
   ) u_fsm (
      .clk   (clk),
      .rst_n (rst_n),
      .req_s (req_s),
      .state (state)
   );

   slp_err_track #(
      .NUM_STROBES (NUM_STROBES),
      .NUM_CE      (NUM_CE)
   ) u_err (
      .clk        (clk),
      .rst_n      (rst_n),
      .state      (state),
      .req_s      (req_s),
      .deselected (deselected),
      .strobe_act (strobe_act),
      .ce_act     (ce_act),
      .proto_err  (proto_err)
   );

   assign sleep_active = (state == ST_ASLEEP);
   assign access_ok    = (state == ST_AWAKE);
   assign force_hiz    = (state != ST_AWAKE);
endmodule

// File: rtl/slp_ctrl_chk.sv
module slp_ctrl_chk #(
   parameter int NUM_STROBES = 2,
   parameter int NUM_CE      = 3
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic [NUM_STROBES-1:0] strobe_act,
   input logic [NUM_CE-1:0]      ce_act,
   input logic                   sleep_active,
   input logic                   access_ok,
   input logic                   force_hiz,
   input logic                   proto_err
);
   // R5
   sleep_floats_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sleep_active |-> force_hiz && !access_ok);

   // R3
   sleep_via_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sleep_active) |-> $past(force_hiz) && !$past(access_ok));

   // R4
   wake_via_recover_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(access_ok) |-> $past(force_hiz) && !$past(sleep_active));

   // R9
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      proto_err |=> proto_err);

   // R7
   act_flags_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (force_hiz && ((|strobe_act) || (|ce_act))) |=> proto_err);
endmodule

bind slp_ctrl slp_ctrl_chk #(
   .NUM_STROBES (NUM_STROBES),
   .NUM_CE      (NUM_CE)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .strobe_act   (strobe_act),
   .ce_act       (ce_act),
   .sleep_active (sleep_active),
   .access_ok    (access_ok),
   .force_hiz    (force_hiz),
   .proto_err    (proto_err)
);

// File: tb/slp_ctrl_tb.sv
module slp_ctrl_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sleep_req = 1'b0;
   logic       deselected = 1'b1;
   logic [1:0] strobe_act = '0;
   logic [2:0] ce_act = '0;
   logic       sleep_active, access_ok, force_hiz, proto_err;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   typedef struct {
      logic  sl, ok, hz, er;
      string tag;
   } exp_t;
   exp_t exp_q[$];

   always #2 clk = ~clk;

   slp_ctrl u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .sleep_req    (sleep_req),
      .deselected   (deselected),
      .strobe_act   (strobe_act),
      .ce_act       (ce_act),
      .sleep_active (sleep_active),
      .access_ok    (access_ok),
      .force_hiz    (force_hiz),
      .proto_err    (proto_err)
   );

   task automatic cmp(input string tag, input string nm, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%b expected=%b", tag, nm, act, exp);
      end
   endtask

   task automatic cmp_all(input string tag, input logic sl, input logic ok, input logic hz, input logic er);
      cmp(tag, "sleep_active", sleep_active, sl);
      cmp(tag, "access_ok", access_ok, ok);
      cmp(tag, "force_hiz", force_hiz, hz);
      cmp(tag, "proto_err", proto_err, er);
   endtask

   // Monitor: one expected item per clock edge, compared after the edge.
   always @(posedge clk) begin
      #1;
      if (exp_q.size() > 0) begin
         exp_t e;
         e = exp_q.pop_front();
         cmp_all(e.tag, e.sl, e.ok, e.hz, e.er);
      end
   end

   // Driver: sets inputs for the coming edge and queues the outputs expected after it.
   task automatic step(input logic rq, input logic ds, input logic [1:0] st, input logic [2:0] ce,
                       input logic sl, input logic ok, input logic hz, input logic er, input string tag);
      exp_t e;
      @(negedge clk);
      sleep_req  = rq;
      deselected = ds;
      strobe_act = st;
      ce_act     = ce;
      e.sl = sl; e.ok = ok; e.hz = hz; e.er = er; e.tag = tag;
      exp_q.push_back(e);
   endtask

   task automatic do_reset(input string tag);
      @(negedge clk);
      sleep_req = 1'b0; deselected = 1'b1; strobe_act = '0; ce_act = '0;
      rst_n = 1'b0;
      #1;
      cmp_all(tag, 1'b0, 1'b1, 1'b0, 1'b0);
      @(negedge clk);
      @(negedge clk);
      cmp_all(tag, 1'b0, 1'b1, 1'b0, 1'b0);
      rst_n = 1'b1;
   endtask

   // Request held high for n samples starting from awake; ends asleep after 5.
   task automatic enter_sleep(input logic ds, input logic er_after, input string tag);
      step(1, ds, 0, 0, 0, 1, 0, 0, {tag, " R2 sync1"});
      step(1, ds, 0, 0, 0, 1, 0, 0, {tag, " R2 sync2"});
      step(1, ds, 0, 0, 0, 0, 1, er_after, {tag, " R2 leave awake"});
      step(1, ds, 0, 0, 0, 0, 1, er_after, {tag, " R3 entry2"});
      step(1, ds, 0, 0, 1, 0, 1, er_after, {tag, " R3 asleep"});
   endtask

   initial begin
      do_reset("R1 reset");

      // Clean entry and exit
      step(0, 1, 0, 0, 0, 1, 0, 0, "R1 idle");
      enter_sleep(1, 0, "clean");
      step(1, 1, 0, 0, 1, 0, 1, 0, "R3 hold asleep");
      step(0, 1, 0, 0, 1, 0, 1, 0, "R4 release sync1");
      step(0, 1, 0, 0, 1, 0, 1, 0, "R4 release sync2");
      step(0, 1, 0, 0, 0, 0, 1, 0, "R4 R5 recover1");
      step(0, 1, 0, 0, 0, 0, 1, 0, "R4 R5 recover2");
      step(0, 1, 0, 0, 0, 1, 0, 0, "R4 awake");
      step(0, 1, 2'b01, 3'b001, 0, 1, 0, 0, "R7 awake activity no error");
      step(0, 1, 2'b10, 3'b110, 0, 1, 0, 0, "R7 awake activity no error 2");

      // Request withdrawn during entry
      step(1, 1, 0, 0, 0, 1, 0, 0, "R6 sync1");
      step(1, 1, 0, 0, 0, 1, 0, 0, "R6 sync2");
      step(0, 1, 0, 0, 0, 0, 1, 0, "R6 entry1");
      step(0, 1, 0, 0, 0, 0, 1, 0, "R6 entry2");
      step(0, 1, 0, 0, 0, 0, 1, 0, "R6 recover no sleep");
      step(0, 1, 0, 0, 0, 0, 1, 0, "R6 recover2");
      step(0, 1, 0, 0, 0, 1, 0, 0, "R6 awake");

      // Strobe while asleep, sticky flag
      enter_sleep(1, 0, "strobe");
      step(1, 1, 2'b01, 0, 1, 0, 1, 1, "R7 strobe asleep");
      step(1, 1, 0, 0, 1, 0, 1, 1, "R9 sticky asleep");
      step(0, 1, 0, 0, 1, 0, 1, 1, "R9 sticky release1");
      step(0, 1, 0, 0, 1, 0, 1, 1, "R9 sticky release2");
      step(0, 1, 0, 0, 0, 0, 1, 1, "R9 sticky recover1");
      step(0, 1, 0, 0, 0, 0, 1, 1, "R9 sticky recover2");
      step(0, 1, 0, 0, 0, 1, 0, 1, "R9 sticky awake");
      do_reset("R9 reset clears");

      // Chip enable during recovery
      enter_sleep(1, 0, "ce");
      step(0, 1, 0, 0, 1, 0, 1, 0, "R7 ce release1");
      step(0, 1, 0, 0, 1, 0, 1, 0, "R7 ce release2");
      step(0, 1, 0, 0, 0, 0, 1, 0, "R7 ce recover1");
      step(0, 1, 0, 3'b100, 0, 0, 1, 1, "R7 ce during recover");
      step(0, 1, 0, 0, 0, 1, 0, 1, "R7 R9 awake flagged");
      do_reset("R10 reset");

      // Request while selected, then reset mid-entry
      step(1, 0, 0, 0, 0, 1, 0, 0, "R8 sync1");
      step(1, 0, 0, 0, 0, 1, 0, 0, "R8 sync2");
      step(1, 0, 0, 0, 0, 0, 1, 1, "R8 selected at entry");
      step(1, 1, 0, 0, 0, 0, 1, 1, "R8 entry2");
      do_reset("R10 reset mid entry");
      step(0, 1, 0, 0, 0, 1, 0, 0, "R10 awake after reset");

      @(negedge clk);
      @(negedge clk);
      if (!done) begin
         done = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++;
         errors++;
         $display("FAIL watchdog R1 actual=timeout expected=finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule